// File: doc/BRIEF.md
# Output Operator Level Compensation

This block keeps the loudness of a voice roughly constant no matter how many operators an algorithm sums into the voice output. It works on log-domain attenuation values. Each operator slot brings a 12-bit log envelope level, where a larger value means a quieter operator. It also brings a 3-bit count field that holds the number of summed output operators minus one. The block looks up a 6-bit log attenuation for that count and adds it to the envelope level. The sum saturates at full attenuation. The result then passes through a parameterized register pipeline, so it leaves the block in step with the rest of the operator datapath. Operators that only modulate carry a count of zero and pass through unscaled.

Table entries are in sixteenths of an octave, rounded to the nearest step. An attenuation of 16 halves the linear level. Neither the conversion back to the linear domain nor the envelope generation is part of this block.

Both data interfaces are valid/ready streams. A word is transferred on a rising edge where valid and ready are both high. While the consumer holds `out_ready` low, the held output word must not change and must not be withdrawn. While that stall lasts, the pipeline keeps accepting new words until all of its stages are occupied, and then lowers `in_ready`. `in_ready` may depend on `out_ready` within the same cycle. `in_valid` must not depend on `in_ready`.

Top module: `lvlcomp_top`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: A count field of 0 produces an output level equal to the input level.
- R3: Count fields 1, 2, 3, 4 and 5 add 16, 25, 32, 37 and 41 to the level. These are the rounded values of 16·log2(k) for division factors k = 2 to 6.
- R4: Count fields 6 and 7 are clamped to the largest entry and add 41.
- R5: The output level saturates at 4095 whenever level plus attenuation would exceed 4095.
- R6: With `out_ready` high and the pipeline empty, a word accepted on one rising edge appears on `out_valid`/`out_level` just after the DEPTH-th rising edge, counting the accepting edge as the first (edge 2 for the default DEPTH of 2).
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_level` stays unchanged.
- R8: While `out_ready` is held high, `in_ready` stays high and one word is accepted every cycle.
- R9: Words leave in the order they were accepted, with none lost or duplicated. At most DEPTH words are in flight, and with the pipeline full and `out_ready` low, `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_count | input | 3 | Summed output operator count minus one |
| in_level | input | 12 | Log envelope attenuation of the operator |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_level | output | 12 | Compensated log attenuation, saturated |

## Verification
The result of a word accepted on edge n is due just after edge n+DEPTH−1 when the pipeline runs freely. Under stalls, it is due at the first output handshake after every earlier accepted word has left. The bench drives inputs on the falling edge and evaluates both handshakes one nanosecond later. At that moment it pushes an arithmetically computed expected level into a queue, or pops the queue and compares against it, so every comparison lines up with the edge on which the transfer actually happens. A dedicated test counts the clock edges from acceptance to the first visible output. Stall tests freeze `out_ready` and recheck the held word on each following cycle.

// File: rtl/lvlcomp_pkg.sv
package lvlcomp_pkg;

  localparam int CNT_W = 3;
  localparam int ATT_W = 6;
  localparam int MAX_FIELD = 5;

  function automatic logic [ATT_W-1:0] att_for_count(input logic [CNT_W-1:0] cnt);
    logic [ATT_W-1:0] a;
    case (cnt)
      3'd0:    a = 6'd0;
      3'd1:    a = 6'd16;
      3'd2:    a = 6'd25;
      3'd3:    a = 6'd32;
      3'd4:    a = 6'd37;
      default: a = 6'd41;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/lvlcomp_att_rom.sv
module lvlcomp_att_rom
  import lvlcomp_pkg::*;
(
  input  logic [CNT_W-1:0] count,
  output logic [ATT_W-1:0] att
);
  logic [CNT_W-1:0] clamped;

  always_comb begin
    if (count > CNT_W'(MAX_FIELD)) clamped = CNT_W'(MAX_FIELD);
    else                           clamped = count;
    att = att_for_count(clamped);
  end
endmodule

// File: rtl/lvlcomp_sat_add.sv
module lvlcomp_sat_add #(
  parameter int LVL_W = 12,
  parameter int ADD_W = 6
) (
  input  logic [LVL_W-1:0] level,
  input  logic [ADD_W-1:0] att,
  output logic [LVL_W-1:0] sum
);
  localparam logic [LVL_W-1:0] FULL = '1;
  logic [LVL_W:0] wide;

  always_comb begin
    wide = {1'b0, level} + (LVL_W+1)'(att);
    if (wide[LVL_W]) sum = FULL;
    else             sum = wide[LVL_W-1:0];
  end
endmodule

// File: rtl/lvlcomp_stage.sv
module lvlcomp_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end
endmodule

// File: rtl/lvlcomp_top.sv
module lvlcomp_top
  import lvlcomp_pkg::*;
#(
  parameter int ENV_W = 12,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CNT_W-1:0] in_count,
  input  logic [ENV_W-1:0] in_level,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ENV_W-1:0] out_level
);
  logic [ATT_W-1:0] att;
  logic [ENV_W-1:0] sum;

  logic             v   [DEPTH+1];
  logic             r   [DEPTH+1];
  logic [ENV_W-1:0] d   [DEPTH+1];

  lvlcomp_att_rom rom_i (
    .count (in_count),
    .att   (att)
  );

  lvlcomp_sat_add #(.LVL_W(ENV_W), .ADD_W(ATT_W)) add_i (
    .level (in_level),
    .att   (att),
    .sum   (sum)
  );

  assign v[0]     = in_valid;
  assign d[0]     = sum;
  assign in_ready = r[0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_pipe
    lvlcomp_stage #(.W(ENV_W)) stage_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (v[g]),
      .up_ready (r[g]),
      .up_data  (d[g]),
      .dn_valid (v[g+1]),
      .dn_ready (r[g+1]),
      .dn_data  (d[g+1])
    );
  end

  assign r[DEPTH]   = out_ready;
  assign out_valid  = v[DEPTH];
  assign out_level  = d[DEPTH];
endmodule

// File: rtl/lvlcomp_chk.sv
module lvlcomp_chk #(
  parameter int ENV_W = 12,
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ENV_W-1:0] out_level
);
  localparam int OCC_W = $clog2(DEPTH + 2) + 1;
  logic [OCC_W-1:0] occ;
  logic acc, emit;

  assign acc  = in_valid && in_ready;
  assign emit = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + OCC_W'(acc) - OCC_W'(emit);
  end

  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_hold_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_level));

  assert_occupancy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  assert_no_phantom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    occ == '0 |-> !out_valid);

  assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    occ == OCC_W'(DEPTH) && !out_ready |-> !in_ready);

  assert_flow_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
endmodule

bind lvlcomp_top lvlcomp_chk #(.ENV_W(ENV_W), .DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_level (out_level)
);

// File: tb/lvlcomp_top_tb_top.sv
`timescale 1ns/1ps
module lvlcomp_top_tb_top;
  localparam int ENV_W = 12;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_count = '0;
  logic [ENV_W-1:0] in_level = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [ENV_W-1:0] out_level;

  always #2.5 clk = ~clk;

  lvlcomp_top #(.ENV_W(ENV_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_count(in_count), .in_level(in_level),
    .out_valid(out_valid), .out_ready(out_ready), .out_level(out_level)
  );

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  int tag_q[$];
  int lfsr = 32'h1ACE5;
  bit accepted;
  bit saw_out;
  bit done = 1'b0;

  function automatic int att_of(int c);
    case (c)
      0: return 0;
      1: return 16;
      2: return 25;
      3: return 32;
      4: return 37;
      default: return 41;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_name(int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic bit rnd();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
    return (lfsr & 3) != 0;
  endfunction

  // Drive on the falling edge, evaluate handshakes for the coming rising edge.
  task automatic cyc(bit iv, int c, int l, bit ordy);
    int s, t;
    in_valid  = iv;
    in_count  = c[2:0];
    in_level  = l[ENV_W-1:0];
    out_ready = ordy;
    #1;
    accepted = 1'b0;
    saw_out  = out_valid;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R9", int'(out_level), -1);
      else begin
        s = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(out_level) == s, tag_name(t), int'(out_level), s);
      end
    end
    if (in_valid && in_ready) begin
      accepted = 1'b1;
      s = l + att_of(c);
      if (s > 4095) begin s = 4095; t = 5; end
      else if (c == 0) t = 2;
      else if (c <= 5) t = 3;
      else t = 4;
      exp_q.push_back(s);
      tag_q.push_back(t);
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && exp_q.size() != 0; k++) cyc(0, 0, 0, 1);
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);
  endtask

  function automatic int lvl_of(int li);
    int sp[6] = '{4054, 4055, 4056, 4079, 4095, 1};
    if (li < 64) return li * 64 + (li % 7);
    return sp[li - 64];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hold, cnt, lat;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(in_ready == 1'b1, "R1", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);

    // R6: latency from an empty pipeline
    cyc(1, 1, 100, 1);
    check(accepted, "R6", accepted, 1);
    lat = 0;
    for (int k = 1; k <= 10 && !saw_out; k++) begin
      cyc(0, 0, 0, 1);
      if (saw_out) lat = k;
    end
    check(lat == DEPTH, "R6", lat, DEPTH);
    drain();

    // Sweep with random output stalls (R2..R5, R9)
    for (int c = 0; c < 8; c++) begin
      for (int li = 0; li < 70; li++) begin
        accepted = 1'b0;
        for (int k = 0; k < 20 && !accepted; k++) cyc(1, c, lvl_of(li), rnd());
      end
    end
    drain();

    // R8: free flow keeps in_ready high
    for (int li = 0; li < 64; li++) begin
      cyc(1, li % 8, lvl_of(li + 3), 1);
      check(accepted, "R8", accepted, 1);
    end
    drain();

    // R9/R7: fill with output blocked
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      cyc(1, 2, 500 + k, 0);
      if (accepted) cnt++;
    end
    check(cnt == DEPTH, "R9", cnt, DEPTH);
    #1;
    check(in_ready == 1'b0, "R9", in_ready, 0);
    hold = int'(out_level);
    for (int k = 0; k < 5; k++) begin
      cyc(0, 0, 0, 0);
      check(out_valid == 1'b1, "R7", out_valid, 1);
      check(int'(out_level) == hold, "R7", int'(out_level), hold);
    end
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule